// File: doc/BRIEF.md
# Interval Countdown Timer

A 32-bit interval timer that software controls through six 16-bit registers on a simple word-addressed bus. A 32-bit period is loaded as two 16-bit halves, and each half-write reloads the running count at once. While the count is enabled, every pulse on the tick input lowers the count by two and stops it at zero. When the count reaches zero it reloads from the period, a timeout flag is set, and the interrupt-enable bit is forced on. The interrupt output is a level that stays high while the timeout flag and the enable bit are both set.

Reads are combinational from the address. The two period registers always return the live count, not the programmed period. The two snapshot registers return the half of the count captured at the moment of the read. Operation is continuous or one-shot. A one-shot run holds whenever the count equals the programmed period. To make a one-shot pass, software starts the count in continuous mode, lets it leave the period value, and then clears the continuous bit. The count then runs to zero, reloads and halts.

Top module: `tmr_interval_top`

## Requirements
- R1: After reset every register reads zero and `irq_o` is low. This includes the internal period and count.
- R2: The register offsets are: 0 status, 1 control, 2 count/period low, 3 count/period high, 4 snapshot low, 5 snapshot high. Control keeps `wdata_i[3:0]` and status keeps only bit 0. Unused bits read zero. Status bit 1 ignores writes. A read at offset 6 or 7 returns zero, and a write there changes nothing.
- R3: A write at offset 2 replaces period bits 15:0 and keeps bits 31:16. A write at offset 3 replaces bits 31:16 and keeps bits 15:0. Either write sets the count to the new period on the same edge, and this takes precedence over a tick in that cycle.
- R4: On an enabled tick, a count above 2 drops by exactly 2. A count of 2 or less becomes zero.
- R5: The count may step only when control bit 2 (start) is 1 and control bit 3 (stop) is 0. Status bit 1 reads 1 exactly when stepping is allowed. A tick that is not allowed leaves the count unchanged.
- R6: When control bit 1 (continuous) is 0 and the count equals the period, stepping is not allowed.
- R7: A tick whose result is zero reloads the count from the period. On the same edge it sets status bit 0 (timeout) and control bit 0 (interrupt enable). These bits win over a status or control write in that cycle.
- R8: `irq_o` is high exactly when control bit 0 and status bit 0 are both 1. A status write with bit 0 at 0 clears the interrupt, unless a timeout occurs in the same cycle.
- R9: A read at offset 4 returns count bits 15:0, and a read at offset 5 returns count bits 31:16, both taken at the time of the read. Period reads at offsets 2 and 3 return the live count in the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | Count step strobe, one step per high cycle |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Word offset for both reads and writes |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Level timeout interrupt |

## Verification
Directed sequences check the register masks, the read-only status bit, writes to unused offsets, and the split loads of the period. Odd and even periods are used so that the saturating step, which ends at 1 on an odd count and at 2 on an even one, is separated from plain decrement. The one-shot run is started in continuous mode and then switched over, which shows the count-equals-period hold apart from a normal stop. Random mixes of ticks, control values, status writes and small period loads then hit the collisions: a timeout together with a status write, and a tick together with a period write. After each cycle every offset and the interrupt are compared with a bench model.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned OFS_STATUS  = 0;
  localparam int unsigned OFS_CTRL    = 1;
  localparam int unsigned OFS_CNT_LO  = 2;
  localparam int unsigned OFS_CNT_HI  = 3;
  localparam int unsigned OFS_SNAP_LO = 4;
  localparam int unsigned OFS_SNAP_HI = 5;

  localparam int unsigned CTL_IEN   = 0;
  localparam int unsigned CTL_CONT  = 1;
  localparam int unsigned CTL_START = 2;
  localparam int unsigned CTL_STOP  = 3;
  localparam int unsigned CTL_W     = 4;

  localparam int unsigned STA_TO  = 0;
  localparam int unsigned STA_RUN = 1;
endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned HALF_W = CNT_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              cont_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [HALF_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              run_o,
  output logic              expire_o
);
  localparam logic [CNT_W-1:0] STEP = CNT_W'(2);

  logic [CNT_W-1:0] count_q, count_d;
  logic [CNT_W-1:0] period_q, period_d;
  logic [CNT_W-1:0] dec;
  logic             step_en;
  logic             load_en;

  always_comb begin
    run_o    = start_i & ~stop_i & (cont_i | (count_q != period_q));
    load_en  = wr_lo_i | wr_hi_i;
    step_en  = tick_i & run_o & ~load_en;
    dec      = (count_q > STEP) ? (count_q - STEP) : '0;
    expire_o = step_en & (dec == '0);

    period_d = period_q;
    count_d  = count_q;
    if (wr_lo_i) begin
      period_d = {period_q[CNT_W-1:HALF_W], wdata_i};
      count_d  = period_d;
    end else if (wr_hi_i) begin
      period_d = {wdata_i, period_q[HALF_W-1:0]};
      count_d  = period_d;
    end else if (expire_o) begin
      count_d  = period_q;
    end else if (step_en) begin
      count_d  = dec;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q  <= '0;
      period_q <= '0;
    end else begin
      if (load_en || step_en) count_q <= count_d;
      if (load_en)            period_q <= period_d;
    end
  end

  assign count_o = count_q;
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned HALF_W = CNT_W / 2,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [HALF_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              run_i,
  input  logic              expire_i,
  output logic              start_o,
  output logic              stop_o,
  output logic              cont_o,
  output logic              wr_lo_o,
  output logic              wr_hi_o,
  output logic [HALF_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [CTL_W-1:0] ctl_q, ctl_d;
  logic             to_q, to_d;
  logic             wr_sta, wr_ctl;

  always_comb begin
    wr_sta  = wr_en_i && (addr_i == ADDR_W'(OFS_STATUS));
    wr_ctl  = wr_en_i && (addr_i == ADDR_W'(OFS_CTRL));
    wr_lo_o = wr_en_i && (addr_i == ADDR_W'(OFS_CNT_LO));
    wr_hi_o = wr_en_i && (addr_i == ADDR_W'(OFS_CNT_HI));

    ctl_d = wr_ctl ? wdata_i[CTL_W-1:0] : ctl_q;
    to_d  = wr_sta ? wdata_i[STA_TO]    : to_q;
    if (expire_i) begin
      ctl_d[CTL_IEN] = 1'b1;
      to_d           = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      to_q  <= 1'b0;
    end else begin
      if (wr_ctl || expire_i) ctl_q <= ctl_d;
      if (wr_sta || expire_i) to_q  <= to_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_W'(OFS_STATUS): begin
        rdata_o[STA_TO]  = to_q;
        rdata_o[STA_RUN] = run_i;
      end
      ADDR_W'(OFS_CTRL):    rdata_o[CTL_W-1:0] = ctl_q;
      ADDR_W'(OFS_CNT_LO),
      ADDR_W'(OFS_SNAP_LO): rdata_o = count_i[HALF_W-1:0];
      ADDR_W'(OFS_CNT_HI),
      ADDR_W'(OFS_SNAP_HI): rdata_o = count_i[CNT_W-1:HALF_W];
      default:              rdata_o = '0;
    endcase
  end

  assign start_o = ctl_q[CTL_START];
  assign stop_o  = ctl_q[CTL_STOP];
  assign cont_o  = ctl_q[CTL_CONT];
  assign irq_o   = ctl_q[CTL_IEN] & to_q;
endmodule

// File: rtl/tmr_interval_top.sv
module tmr_interval_top #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned HALF_W = CNT_W / 2,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [HALF_W-1:0] wdata_i,
  output logic [HALF_W-1:0] rdata_o,
  output logic              irq_o
);
  logic             rst_q_n;
  logic [CNT_W-1:0] count;
  logic             run, expire;
  logic             start, stop, cont, wr_lo, wr_hi;

  tmr_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  tmr_counter #(.CNT_W(CNT_W), .HALF_W(HALF_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .tick_i   (tick_i),
    .start_i  (start),
    .stop_i   (stop),
    .cont_i   (cont),
    .wr_lo_i  (wr_lo),
    .wr_hi_i  (wr_hi),
    .wdata_i  (wdata_i),
    .count_o  (count),
    .run_o    (run),
    .expire_o (expire)
  );

  tmr_regs #(.CNT_W(CNT_W), .HALF_W(HALF_W), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .count_i  (count),
    .run_i    (run),
    .expire_i (expire),
    .start_o  (start),
    .stop_o   (stop),
    .cont_o   (cont),
    .wr_lo_o  (wr_lo),
    .wr_hi_o  (wr_hi),
    .rdata_o  (rdata_o),
    .irq_o    (irq_o)
  );
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned HALF_W = CNT_W / 2,
  parameter int unsigned ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic              tick_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [HALF_W-1:0] wdata_i,
  input logic [CNT_W-1:0]  count,
  input logic              run,
  input logic              irq_o
);
  logic wr_lo, wr_per, wr_sta, stepping;
  assign wr_lo    = wr_en_i && (addr_i == ADDR_W'(2));
  assign wr_per   = wr_en_i && ((addr_i == ADDR_W'(2)) || (addr_i == ADDR_W'(3)));
  assign wr_sta   = wr_en_i && (addr_i == ADDR_W'(0));
  assign stepping = tick_i && run && !wr_per;

  AST_STEP_BY_TWO: assert property (@(posedge clk) disable iff (!rst_q_n)
    (stepping && count > CNT_W'(2)) |=> (count == $past(count) - CNT_W'(2))) // R4
    else $error("step by two");

  AST_ZERO_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_q_n)
    (stepping && count <= CNT_W'(2)) |=> irq_o) // R7
    else $error("zero raises irq");

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!wr_per && !(tick_i && run)) |=> $stable(count)) // R5
    else $error("idle holds");

  AST_LOW_LOAD: assert property (@(posedge clk) disable iff (!rst_q_n)
    wr_lo |=> (count[HALF_W-1:0] == $past(wdata_i))) // R3
    else $error("low load");

  AST_TO_CLEAR: assert property (@(posedge clk) disable iff (!rst_q_n)
    (wr_sta && !wdata_i[0] && !(stepping && count <= CNT_W'(2))) |=> !irq_o) // R8
    else $error("to clear");
endmodule

bind tmr_interval_top tmr_checker #(.CNT_W(CNT_W), .HALF_W(HALF_W), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_q_n (rst_q_n),
  .tick_i  (tick_i),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .count   (count),
  .run     (run),
  .irq_o   (irq_o)
);

// File: tb/test_tmr_interval_top.sv
module test_tmr_interval_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_i, wr_en_i;
  logic [2:0]  addr_i;
  logic [15:0] wdata_i;
  logic [15:0] rdata_o;
  logic        irq_o;

  int unsigned n_chk = 0;
  int unsigned n_err = 0;
  bit          done  = 0;

  logic [31:0] m_cnt, m_per;
  logic [3:0]  m_ctl;
  logic        m_to;

  always #10 clk = ~clk;

  tmr_interval_top i_tmr_interval_top (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  function automatic logic m_allow();
    return m_ctl[2] & ~m_ctl[3] & (m_ctl[1] | (m_cnt != m_per));
  endfunction

  function automatic logic [15:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0:       return {14'd0, m_allow(), m_to};
      3'd1:       return {12'd0, m_ctl};
      3'd2, 3'd4: return m_cnt[15:0];
      3'd3, 3'd5: return m_cnt[31:16];
      default:    return 16'd0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [2:0] a, input logic [15:0] d, input logic tk);
    logic        al;
    logic        wrp;
    logic [31:0] dec;
    @(negedge clk);
    wr_en_i = we; addr_i = a; wdata_i = d; tick_i = tk;
    @(posedge clk);
    al  = m_allow();
    wrp = we && (a == 3'd2 || a == 3'd3);
    if (we) begin
      case (a)
        3'd0: m_to  = d[0];
        3'd1: m_ctl = d[3:0];
        3'd2: begin m_per = {m_per[31:16], d}; m_cnt = m_per; end
        3'd3: begin m_per = {d, m_per[15:0]};  m_cnt = m_per; end
        default: ;
      endcase
    end
    if (tk && al && !wrp) begin
      dec = (m_cnt > 32'd2) ? m_cnt - 32'd2 : 32'd0;
      if (dec == 32'd0) begin
        m_cnt = m_per; m_to = 1'b1; m_ctl[0] = 1'b1;
      end else m_cnt = dec;
    end
    @(negedge clk);
    wr_en_i = 1'b0; tick_i = 1'b0;
  endtask

  task automatic rd(input string req, input logic [2:0] a);
    addr_i = a;
    #1;
    chk(req, {16'd0, rdata_o}, {16'd0, exp_rd(a)});
  endtask

  task automatic rd_lit(input string req, input logic [2:0] a, input logic [15:0] e);
    addr_i = a;
    #1;
    chk(req, {16'd0, rdata_o}, {16'd0, e});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    rst_n = 1'b0; tick_i = 0; wr_en_i = 0; addr_i = 0; wdata_i = 0;
    m_cnt = 0; m_per = 0; m_ctl = 0; m_to = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 8; a++) rd_lit("R1", 3'(a), 16'd0);
    chk("R1 irq", {31'd0, irq_o}, 32'd0);

    // R2 masks and unused offsets
    step(1, 3'd1, 16'hFFF0, 0);  rd_lit("R2 ctrl mask", 3'd1, 16'h0000);
    step(1, 3'd0, 16'hFFFE, 0);  rd_lit("R2 status ro", 3'd0, 16'h0000);
    step(1, 3'd6, 16'h1234, 1);  rd_lit("R2 ofs6", 3'd6, 16'h0);
    rd_lit("R2 ofs6 no effect", 3'd2, 16'h0);

    // R3 split period loads
    step(1, 3'd3, 16'h0001, 0);  rd_lit("R3 hi", 3'd3, 16'h0001);
    step(1, 3'd2, 16'h0007, 0);  rd_lit("R3 lo keeps hi", 3'd3, 16'h0001);
    rd_lit("R3 lo", 3'd2, 16'h0007);
    step(1, 3'd3, 16'h0000, 0);  rd_lit("R3 hi keeps lo", 3'd2, 16'h0007);

    // R6 one-shot holds at count == period
    step(1, 3'd1, 16'h0004, 0);  rd_lit("R6 run low", 3'd0, 16'h0);
    step(0, 3'd0, 16'h0, 1);     rd_lit("R6 held", 3'd2, 16'd7);

    // R4/R5 continuous odd period 7: 5,3,1,reload
    step(1, 3'd1, 16'h0006, 0);  rd_lit("R5 run bit", 3'd0, 16'h0002);
    step(0, 3'd0, 16'h0, 1);     rd_lit("R4 7->5", 3'd2, 16'd5);
    step(0, 3'd0, 16'h0, 0);     rd_lit("R5 no tick", 3'd2, 16'd5);
    step(1, 3'd1, 16'h000E, 0);
    step(0, 3'd0, 16'h0, 1);     rd_lit("R5 stop holds", 3'd2, 16'd5);
    step(1, 3'd1, 16'h0006, 0);
    step(0, 3'd0, 16'h0, 1);     rd_lit("R4 5->3", 3'd4, 16'd3);
    step(0, 3'd0, 16'h0, 1);     rd_lit("R4 3->1", 3'd2, 16'd1);
    chk("R8 no irq yet", {31'd0, irq_o}, 32'd0);
    step(0, 3'd0, 16'h0, 1);     rd_lit("R7 reload", 3'd2, 16'd7);
    rd_lit("R7 to set", 3'd0, 16'h0003);
    rd_lit("R7 ien forced", 3'd1, 16'h0007);
    chk("R8 irq", {31'd0, irq_o}, 32'd1);
    step(1, 3'd0, 16'h0002, 0);  chk("R8 clear", {31'd0, irq_o}, 32'd0);

    // R6 one-shot pass: leave period, clear cont, run to zero and halt
    step(0, 3'd0, 16'h0, 1);
    step(1, 3'd1, 16'h0004, 0);
    repeat (5) step(0, 3'd0, 16'h0, 1);
    rd_lit("R6 halted at period", 3'd2, 16'd7);
    rd_lit("R6 run low", 3'd0, 16'h0001);

    // R9 snapshot of a wide count, R3 tick collides with load
    step(1, 3'd1, 16'h0006, 0);
    step(1, 3'd3, 16'h00AB, 1);
    step(1, 3'd2, 16'h0000, 1);  rd_lit("R3 load wins", 3'd2, 16'h0000);
    step(0, 3'd0, 16'h0, 1);
    rd_lit("R9 snap lo", 3'd4, 16'hFFFE);
    rd_lit("R9 snap hi", 3'd5, 16'h00AA);

    // R7/R8 timeout collides with status clear
    step(1, 3'd3, 16'h0000, 0);
    step(1, 3'd2, 16'h0002, 0);
    step(0, 3'd0, 16'h0, 1);
    step(1, 3'd0, 16'h0000, 1);  chk("R7 timeout wins", {31'd0, irq_o}, 32'd1);

    // random mix
    for (int i = 0; i < 600; i++) begin
      int unsigned op;
      logic [15:0] d;
      op = $urandom % 10;
      d  = 16'($urandom);
      case (op)
        0: step(1, 3'd1, {d[15:4], ($urandom % 4 == 0), d[2:0] | 3'b100}, d[0]);
        1: step(1, 3'd0, d, d[1]);
        2: step(1, 3'd2, 16'($urandom % 12), d[2]);
        3: step(1, 3'd3, ($urandom % 4 == 0) ? 16'd1 : 16'd0, d[3]);
        4: step(1, 3'(6 + ($urandom % 2)), d, d[4]);
        default: step(0, 3'd0, 16'h0, ($urandom % 4 != 0));
      endcase
      rd("R9 random read", 3'($urandom % 8));
      rd("R5 random status", 3'd0);
      rd("R4 random count", 3'd2);
      chk("R8 random irq", {31'd0, irq_o}, {31'd0, m_ctl[0] & m_to});
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule